// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where subroutine returns will go. The fetch stage tells it about each call by giving the call's address. The block then stores the address of the instruction after the call in a small circular stack. A return is flagged by a predecode bit. When a return arrives, the block removes the newest stored address and offers it as the predicted target, in place of whatever the target buffer would have supplied. The current top of the stack and the stack's empty and full state are always visible, so the fetch logic can choose between this prediction and other sources.

The stack has a fixed number of entries. A parameter selects what happens when a call arrives and the stack is already full. In the overwrite policy the oldest entry is discarded. The newest return addresses then stay correct, and mispredictions appear only after the stack has been drained. In the hold policy the stack is left untouched. This keeps the older addresses, but the next return is then predicted wrongly. A return that finds the stack empty gives the fall-through address and marks the prediction as not valid.

Top module: `ras_predictor`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full` is 0, `pred_valid` is 0 and `tos_addr` is 0.
- R2: A call without a return, while the stack is not full, stores `call_pc + INST_BYTES` (4 by default). From the next cycle that value appears on `tos_addr` and `empty` is 0.
- R3: A return without a call, while the stack is not empty, raises `pred_valid` for the next cycle. In that cycle `pred_target` equals the `tos_addr` seen in the cycle of the return, and the entry below becomes the new top.
- R4: Up to DEPTH (4) nested calls are returned in last-in first-out order.
- R5: A return on an empty stack gives `pred_valid` = 0 and `pred_target` = `ret_pc + INST_BYTES` in the next cycle. The stack stays empty.
- R6: When a call and a return come in the same cycle on a non-empty stack, the old top is predicted with `pred_valid` = 1. The top is replaced in place by the new return address, and the occupancy does not change. On an empty stack the same pair gives an invalid fall-through prediction and pushes the new address.
- R7: `full` is 1 exactly when DEPTH entries are held. The occupancy never exceeds DEPTH, and `empty` and `full` are never both 1.
- R8: With WRAP_ON_FULL = 1, a call on a full stack overwrites the oldest entry and becomes the new top. The following DEPTH returns yield the DEPTH newest addresses, and the next return is invalid.
- R9: With WRAP_ON_FULL = 0, a call alone on a full stack changes nothing. `tos_addr` and `full` keep their values.
- R10: `pred_valid` is 1 only in the cycle right after a return. `pred_target` holds its value between returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | A call is being fetched this cycle |
| call_pc | input | ADDR_W | Address of the call instruction |
| ret_valid | input | 1 | Predecode return bit (1 = return) |
| ret_pc | input | ADDR_W | Address of the return instruction |
| pred_valid | output | 1 | Registered: the last return got a stacked target |
| pred_target | output | ADDR_W | Registered predicted return target |
| tos_addr | output | ADDR_W | Current top entry, 0 when empty |
| empty | output | 1 | No entries held |
| full | output | 1 | DEPTH entries held |

## Verification
The bound checker tests every cycle for the following: the one-cycle relation between a push and the new top, a pop and its prediction, an empty pop and the fall-through target, and a paired call and return and the in-place replacement. It also checks that the flags are exclusive, that the pulse is single-cycle, and the full-stack rule of whichever policy is built. Last-in first-out order across several nested calls, and which addresses survive a run of overflowing calls, depend on history longer than one cycle. Only the bench shows these, by comparing both policies against a queue model while a stack is filled, overflowed and drained.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Effective stack operation chosen for one cycle
  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2,
    RAS_SWAP = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int WRAP_ON_FULL = 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output ras_op_e          op,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count
);
  logic [PTR_W-1:0] ptr_q, ptr_up, ptr_dn;
  logic [CNT_W-1:0] cnt_q;
  logic             is_empty, is_full;

  assign ptr_up   = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dn   = (ptr_q == '0) ? PTR_W'(DEPTH - 1) : ptr_q - 1'b1;
  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign count    = cnt_q;

  always_comb begin
    op     = RAS_IDLE;
    wr_en  = 1'b0;
    wr_idx = ptr_up;
    rd_en  = 1'b0;
    rd_idx = ptr_dn;
    case ({push_req, pop_req})
      2'b10: begin
        if (!is_full || (WRAP_ON_FULL != 0)) begin
          op    = RAS_PUSH;
          wr_en = 1'b1;
        end
      end
      2'b01: begin
        if (!is_empty) begin
          op    = RAS_POP;
          rd_en = 1'b1;
        end
      end
      2'b11: begin
        wr_en = 1'b1;
        if (is_empty) begin
          op = RAS_PUSH;
        end else begin
          op     = RAS_SWAP;
          wr_idx = ptr_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= PTR_W'(DEPTH - 1);
      cnt_q <= '0;
    end else begin
      case (op)
        RAS_PUSH: begin
          ptr_q <= ptr_up;
          if (!is_full) cnt_q <= cnt_q + 1'b1;
        end
        RAS_POP: begin
          ptr_q <= ptr_dn;
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  // One write port, one registered read port, no reset: RAM-inferable
  logic [ADDR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
  import ras_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DEPTH        = 4,
  parameter int INST_BYTES   = 4,
  parameter int WRAP_ON_FULL = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_valid,
  input  logic [ADDR_W-1:0] call_pc,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_pc,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] tos_addr,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  ras_op_e           op;
  logic              wr_en, rd_en;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] link_addr, fall_addr, rd_data, top_now;
  logic [ADDR_W-1:0] push_q;
  logic              from_mem_q;

  assign link_addr = call_pc + STEP;
  assign fall_addr = ret_pc + STEP;

  ras_ctrl #(.DEPTH(DEPTH), .WRAP_ON_FULL(WRAP_ON_FULL)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(call_valid), .pop_req(ret_valid),
    .op(op), .wr_en(wr_en), .wr_idx(wr_idx), .rd_en(rd_en),
    .rd_idx(rd_idx), .count(count)
  );

  ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(link_addr),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // Top entry: the last pushed value, or the entry read back after a pop
  assign top_now  = from_mem_q ? rd_data : push_q;
  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign tos_addr = empty ? '0 : top_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      push_q      <= '0;
      from_mem_q  <= 1'b0;
      pred_valid  <= 1'b0;
      pred_target <= '0;
    end else begin
      if (op == RAS_POP) begin
        from_mem_q <= 1'b1;
      end else if (op != RAS_IDLE) begin
        from_mem_q <= 1'b0;
        push_q     <= link_addr;
      end
      pred_valid <= 1'b0;
      if (ret_valid) begin
        if (!empty) begin
          pred_valid  <= 1'b1;
          pred_target <= top_now;
        end else begin
          pred_target <= fall_addr;
        end
      end
    end
  end
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int ADDR_W       = 32,
  parameter int INST_BYTES   = 4,
  parameter int WRAP_ON_FULL = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              call_valid,
  input logic [ADDR_W-1:0] call_pc,
  input logic              ret_valid,
  input logic [ADDR_W-1:0] ret_pc,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_target,
  input logic [ADDR_W-1:0] tos_addr,
  input logic              empty,
  input logic              full
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (empty && !full && !pred_valid && tos_addr == '0)); // R1

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
    (call_valid && !ret_valid && !full) |=>
      (!empty && tos_addr == $past(call_pc) + STEP)); // R2

  AST_POP_PREDICT: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !call_valid && !empty) |=>
      (pred_valid && pred_target == $past(tos_addr))); // R3

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && empty) |=>
      (!pred_valid && pred_target == $past(ret_pc) + STEP)); // R5

  AST_SWAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && call_valid && !empty) |=>
      (pred_valid && !empty && $stable(full) &&
       tos_addr == $past(call_pc) + STEP)); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R7

  AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> !pred_valid); // R10

  generate
    if (WRAP_ON_FULL != 0) begin : g_wrap
      AST_WRAP_FULL: assert property (@(posedge clk) disable iff (rst)
        (call_valid && !ret_valid && full) |=>
          (full && tos_addr == $past(call_pc) + STEP)); // R8
    end else begin : g_hold
      AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (call_valid && !ret_valid && full) |=>
          (full && $stable(tos_addr))); // R9
    end
  endgenerate
endmodule

bind ras_predictor ras_checker #(
  .ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES), .WRAP_ON_FULL(WRAP_ON_FULL)
) u_chk (
  .clk(clk), .rst(rst), .call_valid(call_valid), .call_pc(call_pc),
  .ret_valid(ret_valid), .ret_pc(ret_pc), .pred_valid(pred_valid),
  .pred_target(pred_target), .tos_addr(tos_addr), .empty(empty), .full(full)
);

// File: tb/ras_predictor_test.sv
`timescale 1ns/1ps
module ras_predictor_test;
  localparam int AW = 32;
  localparam int D  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_valid = 1'b0, ret_valid = 1'b0;
  logic [AW-1:0] call_pc = '0, ret_pc = '0;
  logic          pv_w, pv_h, em_w, em_h, fu_w, fu_h;
  logic [AW-1:0] pt_w, pt_h, ts_w, ts_h;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ras_predictor #(.ADDR_W(AW), .DEPTH(D), .INST_BYTES(4), .WRAP_ON_FULL(1)) uut (
    .clk(clk), .rst(rst), .call_valid(call_valid), .call_pc(call_pc),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .pred_valid(pv_w),
    .pred_target(pt_w), .tos_addr(ts_w), .empty(em_w), .full(fu_w));

  ras_predictor #(.ADDR_W(AW), .DEPTH(D), .INST_BYTES(4), .WRAP_ON_FULL(0)) uut_hold (
    .clk(clk), .rst(rst), .call_valid(call_valid), .call_pc(call_pc),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .pred_valid(pv_h),
    .pred_target(pt_h), .tos_addr(ts_h), .empty(em_h), .full(fu_h));

  // Behavioural reference: one queue per policy, newest entry at the back
  logic [AW-1:0] qw[$];
  logic [AW-1:0] qh[$];
  logic          m_pv_w = 1'b0, m_pv_h = 1'b0;
  logic [AW-1:0] m_pt_w = '0, m_pt_h = '0;

  task automatic model_one(input bit wrap, input logic c, input logic [AW-1:0] cpc,
                           input logic r, input logic [AW-1:0] rpc);
    logic [AW-1:0] q[$];
    logic          pv;
    logic [AW-1:0] pt;
    q  = wrap ? qw : qh;
    pv = 1'b0;
    pt = wrap ? m_pt_w : m_pt_h;
    if (r) begin
      if (q.size() > 0) begin
        pt = q.pop_back();
        pv = 1'b1;
      end else begin
        pt = rpc + 4;
      end
    end
    if (c) begin
      if (q.size() < D) q.push_back(cpc + 4);
      else if (wrap) begin
        void'(q.pop_front());
        q.push_back(cpc + 4);
      end
    end
    if (wrap) begin qw = q; m_pv_w = pv; m_pt_w = pt; end
    else      begin qh = q; m_pv_h = pv; m_pt_h = pt; end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "wrap pred_valid", AW'(pv_w), AW'(m_pv_w));
    chk(tag, "wrap pred_target", pt_w, m_pt_w);
    chk(tag, "wrap tos_addr", ts_w, (qw.size() > 0) ? qw[$] : '0);
    chk(tag, "wrap empty", AW'(em_w), AW'(qw.size() == 0));
    chk(tag, "wrap full", AW'(fu_w), AW'(qw.size() == D));
    chk(tag, "hold pred_valid", AW'(pv_h), AW'(m_pv_h));
    chk(tag, "hold pred_target", pt_h, m_pt_h);
    chk(tag, "hold tos_addr", ts_h, (qh.size() > 0) ? qh[$] : '0);
    chk(tag, "hold empty", AW'(em_h), AW'(qh.size() == 0));
    chk(tag, "hold full", AW'(fu_h), AW'(qh.size() == D));
  endtask

  // Inputs change at the falling edge; outputs are compared at the next one
  task automatic cyc(input logic c, input logic [AW-1:0] cpc,
                     input logic r, input logic [AW-1:0] rpc, input string tag);
    call_valid = c; call_pc = cpc; ret_valid = r; ret_pc = rpc;
    @(posedge clk);
    model_one(1'b1, c, cpc, r, rpc);
    model_one(1'b0, c, cpc, r, rpc);
    @(negedge clk);
    call_valid = 1'b0; ret_valid = 1'b0;
    compare_all(tag);
  endtask

  task automatic push(input logic [AW-1:0] a, input string tag);
    cyc(1'b1, a, 1'b0, '0, tag);
  endtask

  task automatic pop(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, '0, 1'b1, a, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare_all("R1");

    // Nested calls, then unwind in reverse order
    push(32'h0000_FC34, "R2");
    chk("R2", "wrap tos literal", ts_w, 32'h0000_FC38);
    push(32'h0000_FD08, "R4");
    push(32'h0000_FFB0, "R4");
    push(32'h0000_64AC, "R7");
    chk("R7", "wrap full literal", AW'(fu_w), 32'd1);
    pop(32'h0000_1B9C, "R3");
    chk("R3", "wrap pred literal", pt_w, 32'h0000_64B0);
    pop(32'h0000_1B9C, "R4");
    pop(32'h0000_1B9C, "R4");
    pop(32'h0000_1B9C, "R4");
    chk("R4", "hold last pred literal", pt_h, 32'h0000_FC38);
    pop(32'h0000_2000, "R5");
    chk("R5", "fall-through literal", pt_w, 32'h0000_2004);
    cyc(1'b0, '0, 1'b0, '0, "R10");
    cyc(1'b0, '0, 1'b0, '0, "R10");

    // Overflow under both policies, then drain past empty
    for (int i = 1; i <= D; i++) push(AW'(i * 32'h100), "R7");
    push(32'h0000_0500, "R8");
    push(32'h0000_0600, "R9");
    chk("R9", "hold tos unchanged", ts_h, 32'h0000_0404);
    chk("R8", "wrap tos newest", ts_w, 32'h0000_0604);
    for (int i = 0; i <= D; i++) pop(32'h0000_3000, "R8");

    // Simultaneous call and return, non-empty then empty
    push(32'h0000_0700, "R2");
    cyc(1'b1, 32'h0000_0800, 1'b1, 32'h0000_4000, "R6");
    chk("R6", "swap pred literal", pt_w, 32'h0000_0704);
    pop(32'h0000_4000, "R6");
    cyc(1'b1, 32'h0000_0900, 1'b1, 32'h0000_5000, "R6");
    pop(32'h0000_5000, "R3");
    cyc(1'b0, '0, 1'b0, '0, "R10");

    // Reset in the middle of activity
    push(32'h0000_0A00, "R2");
    rst = 1'b1;
    @(posedge clk);
    qw.delete(); qh.delete();
    m_pv_w = 1'b0; m_pv_h = 1'b0; m_pt_w = '0; m_pt_h = '0;
    @(negedge clk);
    rst = 1'b0;
    compare_all("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule